// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block sends bytes on an asynchronous serial line. Each frame has a low start bit, eight data bits with the least significant bit first, and one high stop bit. The block has two stages. A holding register accepts a byte from the host. Behind it, a frame shifter drives the line. The host can therefore queue the next byte while the current one is still going out, and successive frames follow each other with no idle gap.

Bit timing comes from an enable input that pulses sixteen times per bit period. Each bit on the line lasts sixteen of these pulses. The frame shifter has no host access. The holding register can be read back at any time.

Two flags report progress. The empty flag tells the host it may write again. The busy flag stays high until the last stop bit has left the line and nothing is waiting.

Top module: `dbuf_uart_tx`

## Requirements
- R1: After reset, `txd` is 1, `buf_empty` is 1 and `tx_busy` is 0.
- R2: A write while nothing is sending sets `buf_empty` to 0 and `tx_busy` to 1 in the next cycle. One cycle later the byte moves into the shifter, the start bit (`txd` = 0) begins, and `buf_empty` returns to 1.
- R3: A frame is one start bit of 0, then `wr_data[0]` through `wr_data[7]` in that order, then a stop bit of 1. Each bit holds for exactly 16 `tick16` pulses.
- R4: A write always clears `buf_empty` in the next cycle, including while a frame is being sent. The flag stays 0 until the pending byte is taken by the shifter.
- R5: When a byte is pending, it is loaded on the same tick that ends the stop bit of the current frame. On that tick the next start bit begins with no idle time, and `buf_empty` becomes 1.
- R6: `tx_busy` stays 1 through the whole stop bit. It falls on the tick that ends the last stop bit only when no byte is pending. While `tx_busy` is 0, `txd` is 1.
- R7: A second write while a byte is still pending replaces that byte. The replaced byte is never sent.
- R8: `hold_q` shows the most recently written byte starting from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Enable pulse, 16 per bit time |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to queue |
| hold_q | output | 8 | Read-back of the holding register |
| txd | output | 1 | Serial output line, idles high |
| buf_empty | output | 1 | Holding register can accept a byte |
| tx_busy | output | 1 | A frame is being sent or a byte is waiting |

## Verification
The bench sends six single bytes, one at a time, and samples each bit at its midpoint. The set includes alternating bit patterns, all zeros, all ones, and bytes with a single bit set at either end. Together these separate a correct least-significant-bit-first order from a reversed order, from bits shifted by one position, and from a missing or inverted start or stop bit. A byte with only bit 0 set is used to count the length of the start bit in ticks, which would expose an off-by-one in the bit timer. Back-to-back writes and a pair of overwriting writes show whether a pending byte is loaded exactly when the stop bit ends, whether a replaced byte leaks onto the line, and whether the busy flag falls early, late, or not at all.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int UTX_DATA_W_DEF = 8;
  localparam int UTX_OVS_DEF    = 16;

  // start bit + data bits + one stop bit
  function automatic int frame_len(input int data_w);
    return data_w + 2;
  endfunction

  // width needed to count 0 .. n-1
  function automatic int count_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load,
  output logic [DATA_W-1:0] hold_q,
  output logic              full
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      full   <= 1'b0;
    end else if (wr_en) begin
      hold_q <= wr_data;   // overwrites any pending byte
      full   <= 1'b1;
    end else if (load) begin
      full   <= 1'b0;
    end
  end

  // R4: a write leaves the register occupied
  a_r4_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> full);
  // R2, R5: a load with no competing write frees the register
  a_r5_load_frees: assert property (@(posedge clk) disable iff (!rst_n)
    load && !wr_en |=> !full);
  // R8: read-back shows the last byte written
  a_r8_readback: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> hold_q == $past(wr_data));
endmodule

// File: rtl/uart_tx_bittimer.sv
module uart_tx_bittimer #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic active,
  input  logic restart,
  output logic bit_end
);
  localparam int CW = uart_tx_pkg::count_w(OVS);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nx;

  generate
    if ((OVS & (OVS - 1)) == 0) begin : g_pow2
      assign cnt_nx = cnt + 1'b1;
    end else begin : g_mod
      assign cnt_nx = (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  endgenerate

  assign bit_end = active && tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (restart)        cnt <= '0;
    else if (active && tick) cnt <= cnt_nx;
  end

  // R3: bit time advances only on enable pulses
  a_r3_frozen_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !restart |=> $stable(cnt));
  // R3: a bit ends only on an enable pulse
  a_r3_end_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |-> tick);
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              bit_end,
  output logic              active,
  output logic              frame_end,
  output logic              txd
);
  localparam int FRAME_W = uart_tx_pkg::frame_len(DATA_W);
  localparam int IW      = uart_tx_pkg::count_w(FRAME_W);
  localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_W - 1);

  function automatic logic [FRAME_W-1:0] frame_of(input logic [DATA_W-1:0] d);
    return {1'b1, d, 1'b0};
  endfunction

  logic [FRAME_W-1:0] sr;
  logic [IW-1:0]      idx;

  assign frame_end = bit_end && (idx == LAST_IDX);
  assign txd       = active ? sr[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr     <= '1;
      idx    <= '0;
      active <= 1'b0;
    end else if (load) begin
      sr     <= frame_of(load_data);
      idx    <= '0;
      active <= 1'b1;
    end else if (frame_end) begin
      active <= 1'b0;
    end else if (bit_end) begin
      sr     <= {1'b1, sr[FRAME_W-1:1]};
      idx    <= idx + 1'b1;
    end
  end

  // R2: every load opens with a low start bit
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !txd);
  // R3: the last bit of a frame is the high stop bit
  a_r3_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> txd);
endmodule

// File: rtl/dbuf_uart_tx.sv
module dbuf_uart_tx #(
  parameter int DATA_W = uart_tx_pkg::UTX_DATA_W_DEF,
  parameter int OVS    = uart_tx_pkg::UTX_OVS_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] hold_q,
  output logic              txd,
  output logic              buf_empty,
  output logic              tx_busy
);
  logic full;
  logic active;
  logic bit_end;
  logic frame_end;
  logic load_ev;

  // pending byte enters the shifter when idle or right as a stop bit ends
  assign load_ev   = full && (!active || frame_end);
  assign buf_empty = !full;
  assign tx_busy   = active || full;

  uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .load(load_ev), .hold_q(hold_q), .full(full)
  );

  uart_tx_bittimer #(.OVS(OVS)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .active(active),
    .restart(load_ev), .bit_end(bit_end)
  );

  uart_tx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load_ev), .load_data(hold_q),
    .bit_end(bit_end), .active(active), .frame_end(frame_end), .txd(txd)
  );

  // R1, R6: line is high whenever nothing is in flight
  a_r6_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);
  // R6: busy drops only right after a stop bit finishes
  a_r6_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_busy) |-> $past(frame_end));
  // R5: a pending byte at frame end is taken without a gap
  a_r5_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end && full |=> active && !txd);
endmodule

// File: tb/sim_dbuf_uart_tx.sv
module sim_dbuf_uart_tx;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] hold_q;
  logic       txd, buf_empty, tx_busy;

  int n_chk = 0;
  int n_err = 0;
  int tick_cnt = 0;

  dbuf_uart_tx u0 (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_en(wr_en),
    .wr_data(wr_data), .hold_q(hold_q), .txd(txd),
    .buf_empty(buf_empty), .tx_busy(tx_busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial forever begin
    @(negedge clk);
    tick16 = ~tick16;
  end

  always @(posedge clk) if (rst_n && tick16) tick_cnt <= tick_cnt + 1;

  // {data byte, expected 10-bit frame, bit 0 sent first}
  localparam logic [17:0] VEC [6] = '{
    {8'h55, 10'h2AA}, {8'hA5, 10'h34A}, {8'h00, 10'h200},
    {8'hFF, 10'h3FE}, {8'h01, 10'h202}, {8'h80, 10'h300}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_tick(input int target);
    while (tick_cnt < target) @(negedge clk);
  endtask

  task automatic wait_start(output int t0);
    while (txd !== 1'b0) @(negedge clk);
    t0 = tick_cnt;
  endtask

  task automatic grab(input int t0, output logic [9:0] bits);
    for (int k = 0; k < 10; k++) begin
      wait_tick(t0 + 8 + 16 * k);
      bits[k] = txd;
    end
  endtask

  initial begin
    int t0, t1;
    logic [9:0] bits;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 txd", 32'(txd), 32'd1);
    chk("R1 buf_empty", 32'(buf_empty), 32'd1);
    chk("R1 tx_busy", 32'(tx_busy), 32'd0);

    // vector table, R3
    foreach (VEC[i]) begin
      put(VEC[i][17:10]);
      wait_start(t0);
      grab(t0, bits);
      chk("R3 frame", 32'(bits), 32'(VEC[i][9:0]));
      wait_tick(t0 + 160);
      chk("R6 busy after frame", 32'(tx_busy), 32'd0);
    end

    // R2 write into idle block, cycle by cycle
    put(8'h3C);
    chk("R2 empty cleared", 32'(buf_empty), 32'd0);
    chk("R2 busy set", 32'(tx_busy), 32'd1);
    chk("R2 line still idle", 32'(txd), 32'd1);
    @(negedge clk);
    chk("R2 start bit", 32'(txd), 32'd0);
    chk("R2 empty again", 32'(buf_empty), 32'd1);
    chk("R8 readback", 32'(hold_q), 32'h3C);
    t0 = tick_cnt;
    grab(t0, bits);
    chk("R3 frame 3C", 32'(bits), 32'h278);
    wait_tick(t0 + 160);
    chk("R6 busy low", 32'(tx_busy), 32'd0);
    chk("R6 idle high", 32'(txd), 32'd1);

    // R3 start bit length in ticks
    put(8'h01);
    wait_start(t0);
    while (txd === 1'b0) @(negedge clk);
    chk("R3 bit length", 32'(tick_cnt - t0), 32'd16);
    wait_tick(t0 + 160);

    // R4 R5 back to back
    put(8'h96);
    @(negedge clk);
    t0 = tick_cnt;
    put(8'h5A);
    chk("R4 empty cleared mid frame", 32'(buf_empty), 32'd0);
    chk("R4 busy", 32'(tx_busy), 32'd1);
    grab(t0, bits);
    chk("R3 frame 96", 32'(bits), 32'h32C);
    chk("R4 still pending", 32'(buf_empty), 32'd0);
    wait_tick(t0 + 160);
    chk("R5 start no gap", 32'(txd), 32'd0);
    chk("R5 empty at load", 32'(buf_empty), 32'd1);
    chk("R5 busy held", 32'(tx_busy), 32'd1);
    t1 = t0 + 160;
    grab(t1, bits);
    chk("R5 frame 5A", 32'(bits), 32'h2B4);
    wait_tick(t1 + 160);
    chk("R6 busy low after pair", 32'(tx_busy), 32'd0);

    // R7 overwrite of pending byte
    put(8'h11);
    @(negedge clk);
    t0 = tick_cnt;
    put(8'h22);
    put(8'hE7);
    chk("R8 readback after overwrite", 32'(hold_q), 32'hE7);
    grab(t0, bits);
    chk("R3 frame 11", 32'(bits), 32'h222);
    chk("R6 busy in stop bit", 32'(tx_busy), 32'd1);
    wait_tick(t0 + 160);
    t1 = t0 + 160;
    grab(t1, bits);
    chk("R7 replaced byte sent", 32'(bits), 32'h3CE);
    wait_tick(t1 + 160);
    chk("R6 busy low at end", 32'(tx_busy), 32'd0);
    chk("R7 empty at end", 32'(buf_empty), 32'd1);
    repeat (40) @(negedge clk);
    chk("R6 line idle", 32'(txd), 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule